// File: doc/BRIEF.md
# Column-Serial Table-Lookup Multiplier

This block multiplies two unsigned 4-bit operands into an 8-bit product without any adder tree. A pulse on `start` captures both operands. The block then walks the result columns one per clock, from the least significant column to the most significant. In each column it forms the partial-product bits that belong to that column. A small lookup table takes those bits together with the carry left over from the previous column. The table returns the result bit for that column and the carry for the next one. Seven clock cycles produce the whole product.

The table holds 128 words of 4 bits. Its contents are computed during elaboration, so the only arithmetic element is a stored table. This suits designs where fault-sensitive combinational logic is to be replaced by storage that can be protected separately. The start/done pair is a plain control handshake. There is no back-pressure. A `start` that arrives while a product is being built is dropped. A finished product stays on `product` until the next one completes.

Top module: `colrom_mul4`

## Requirements
- R1: After reset, `product` is 0 and `done` is 0.
- R2: For every pair of unsigned operands, the product reported at completion equals `op_a * op_b`.
- R3: If `start` is sampled on clock edge E while the block is idle, `done` goes high after edge E+7 and stays high for exactly one cycle.
- R4: The operands are captured only on the edge that accepts `start`. Later changes on `op_a` and `op_b` have no effect on the result.
- R5: A `start` sampled while a product is being built, including on the last column's edge, is ignored. The run is neither restarted nor delayed, and the result belongs to the operands originally accepted.
- R6: `product` changes only on the edge that raises `done`. At all other times it holds its last value, including while the next product is being built.
- R7: The lookup address is 7 bits: the 4 partial-product bits of column k in bits 6..3, where bit 3+i is `a[i] & b[k-i]` (0 when k-i is outside 0..3), followed by the 3-bit carry-in in bits 2..0. The 4-bit word is the count of ones among the partial-product bits plus the carry-in. Bit 0 of the word is the column's result bit, and bits 3..1 are the carry-out.
- R8: The column carry is cleared when a run is accepted, so a result never depends on the previous operands.
- R9: A `start` presented in the cycle where `done` is high is accepted and begins a new run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse that requests a multiplication; ignored while busy |
| op_a | input | 4 | Unsigned multiplicand, captured with `start` |
| op_b | input | 4 | Unsigned multiplier, captured with `start` |
| product | output | 8 | Last completed product, held between completions |
| done | output | 1 | One-cycle flag marking a new `product` |

## Verification
The hardest situation to reach from the ports is a `start` that lands in the middle of a run, and in particular one on the final column's edge, just before the block goes idle. The bench places a stray start, with different operands, on a chosen cycle of the run: each cycle from the first to the seventh is covered by directed runs, and random runs pick the cycle at random. A companion case places a start in the `done` cycle itself, which must be accepted. Carry clearing is reached by following a 15×15 run directly with a 0×0 run, so that stale carries would show up in the result.

// File: rtl/colrom_pkg.sv
`timescale 1ns/1ps
package colrom_pkg;

  // Sum of the column bits found above the carry field, plus the carry field itself.
  function automatic int column_total(int addr, int n_pp, int cw);
    int t;
    t = addr & ((1 << cw) - 1);
    for (int i = 0; i < n_pp; i++) begin
      t += (addr >> (cw + i)) & 1;
    end
    return t;
  endfunction

endpackage

// File: rtl/colrom_table.sv
`timescale 1ns/1ps
module colrom_table #(
  parameter int OP_W = 4,
  parameter int CW   = 3
) (
  input  logic [OP_W+CW-1:0] addr,
  output logic [CW:0]        data
);
  localparam int AW    = OP_W + CW;
  localparam int DW    = CW + 1;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] tbl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    assign tbl[g] = DW'(colrom_pkg::column_total(g, OP_W, CW));
  end

  assign data = tbl[addr];
endmodule

// File: rtl/colrom_ppgen.sv
`timescale 1ns/1ps
module colrom_ppgen #(
  parameter int OP_W = 4,
  parameter int NCOL = 2 * OP_W - 1,
  parameter int COLW = $clog2(NCOL)
) (
  input  logic [OP_W-1:0] a,
  input  logic [OP_W-1:0] b,
  input  logic [COLW-1:0] col,
  output logic [OP_W-1:0] pp
);
  for (genvar i = 0; i < OP_W; i++) begin : g_pp
    logic [NCOL-1:0] b_shift;
    assign b_shift = NCOL'(b) << i;
    // b_shift[col] is b[col-i] when in range, zero otherwise
    assign pp[i] = a[i] & b_shift[col];
  end
endmodule

// File: rtl/colrom_seq.sv
`timescale 1ns/1ps
module colrom_seq #(
  parameter int NCOL = 7,
  parameter int COLW = $clog2(NCOL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            busy,
  output logic [COLW-1:0] col,
  output logic            accept,
  output logic            last
);
  localparam logic [COLW-1:0] LAST_COL = COLW'(NCOL - 1);

  logic            busy_q;
  logic [COLW-1:0] col_q;

  assign busy   = busy_q;
  assign col    = col_q;
  assign accept = start && !busy_q;
  assign last   = busy_q && (col_q == LAST_COL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      col_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      col_q  <= '0;
    end else if (busy_q) begin
      if (last) busy_q <= 1'b0;
      else      col_q  <= col_q + 1'b1;
    end
  end

  // R5
  restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> (busy && col == $past(col) + 1'b1));

  col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (col <= LAST_COL));
endmodule

// File: rtl/colrom_mul4.sv
`timescale 1ns/1ps
module colrom_mul4 #(
  parameter int OP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [OP_W-1:0]   op_a,
  input  logic [OP_W-1:0]   op_b,
  output logic [2*OP_W-1:0] product,
  output logic              done
);
  localparam int NCOL = 2 * OP_W - 1;
  localparam int COLW = $clog2(NCOL);
  localparam int CW   = $clog2(OP_W) + 1;
  localparam int PW   = 2 * OP_W;

  logic            busy, accept, last;
  logic [COLW-1:0] col;
  logic [OP_W-1:0] a_q, b_q, pp;
  logic [CW-1:0]   carry_q;
  logic [CW:0]     word;
  logic            sum_bit;
  logic [CW-1:0]   carry_nx;
  logic [NCOL-2:0] acc_q;
  logic [PW-1:0]   product_q;
  logic            done_q;

  colrom_seq #(.NCOL(NCOL), .COLW(COLW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(busy), .col(col), .accept(accept), .last(last)
  );

  colrom_ppgen #(.OP_W(OP_W), .NCOL(NCOL), .COLW(COLW)) u_pp (
    .a(a_q), .b(b_q), .col(col), .pp(pp)
  );

  colrom_table #(.OP_W(OP_W), .CW(CW)) u_tbl (
    .addr({pp, carry_q}), .data(word)
  );

  assign sum_bit  = word[0];
  assign carry_nx = word[CW:1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q       <= '0;
      b_q       <= '0;
      carry_q   <= '0;
      acc_q     <= '0;
      product_q <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= last;
      if (accept) begin
        a_q     <= op_a;
        b_q     <= op_b;
        carry_q <= '0;
      end else if (busy) begin
        carry_q <= carry_nx;
        if (last) product_q <= {carry_nx[0], sum_bit, acc_q};
        else      acc_q[col] <= sum_bit;
      end
    end
  end

  assign product = product_q;
  assign done    = done_q;

  // R7
  table_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(word) == $countones(pp) + int'(carry_q)));

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(last));

  // R6
  product_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(product));

  // R8
  carry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (carry_q == '0));
endmodule

// File: tb/sim_colrom_mul4.sv
`timescale 1ns/1ps
module sim_colrom_mul4;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] op_a = '0, op_b = '0;
  logic [7:0] product;
  logic       done;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] prev_prod = '0;

  always #2.5 clk = ~clk;

  colrom_mul4 u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .op_a(op_a), .op_b(op_b), .product(product), .done(done)
  );

  function automatic logic [7:0] model_mul(logic [3:0] x, logic [3:0] y);
    return 8'(int'(x) * int'(y));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Entered and left at a falling edge. poke_at: edge (1..7) carrying a stray start.
  task automatic run_mul(input logic [3:0] x, input logic [3:0] y,
                         input int poke_at, input bit chain);
    logic [7:0] expv;
    expv = model_mul(x, y);
    op_a = x; op_b = y; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    op_a = 4'($urandom); op_b = 4'($urandom);   // R4: late operand changes
    for (int i = 1; i <= 7; i++) begin
      if (i == poke_at) begin
        start = 1'b1; op_a = ~x; op_b = y + 4'd3;  // R5: stray start
      end
      @(posedge clk); @(negedge clk);
      start = 1'b0;
      if (i < 7) begin
        check(done == 1'b0, "R3 done early", done, 0);
        check(product == prev_prod, "R6 product moved mid-run", product, prev_prod);
      end else begin
        check(done == 1'b1, "R3 done at edge 7", done, 1);
        check(product == expv, "R2/R4/R5 product", product, expv);
      end
    end
    prev_prod = expv;
    if (!chain) begin
      @(posedge clk); @(negedge clk);
      check(done == 1'b0, "R3 done longer than one cycle", done, 0);
      check(product == prev_prod, "R6 product not held", product, prev_prod);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(product == 8'd0, "R1 product after reset", product, 0);
    check(done == 1'b0, "R1 done after reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corners
    run_mul(4'd0, 4'd0, 0, 1'b0);
    run_mul(4'd15, 4'd15, 0, 1'b1);   // R8: max carries, then chained
    run_mul(4'd0, 4'd0, 0, 1'b0);     // R9 + R8: accepted in done cycle, result 0
    run_mul(4'd15, 4'd0, 0, 1'b0);
    run_mul(4'd1, 4'd1, 0, 1'b0);
    run_mul(4'd8, 4'd8, 0, 1'b0);
    // R5: stray start on every edge of a run, including the last column
    for (int p = 1; p <= 7; p++) run_mul(4'd10, 4'd13, p, 1'b0);

    // Exhaustive operand sweep, alternating chained starts (R2, R9)
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++)
        run_mul(4'(x), 4'(y), 0, 1'(y & 1));

    // Random mix
    for (int k = 0; k < 300; k++) begin
      run_mul(4'($urandom), 4'($urandom), int'($urandom % 8), 1'($urandom % 2));
    end

    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule